// File: doc/BRIEF.md
# Definite-Time Overcurrent Element with Torque Control

This block is a single protection element that watches one precomputed, unsigned current magnitude. Each valid sample is compared against a programmable pickup threshold, and the result is gated by a torque-control enable. The element produces two outputs. The pickup flag is instantaneous. The trip flag is delayed and asserts only after pickup has held without a break for a programmable number of valid processing ticks. The same element serves a negative-sequence quantity and a residual quantity; only the magnitude fed in and the settings differ between the two uses.

The timer has no dropout memory. When the pickup condition disappears on a valid tick, the count and both outputs clear on that same tick. The pickup threshold and delay are captured from their inputs on every clock in which pickup is low, and they are frozen while pickup is high. A setting change made during timing therefore cannot disturb the count in progress.

Top module: `dt_oc_element`

## Requirements
- R1: The comparison is true only when the sample magnitude is strictly greater than the active pickup setting; a magnitude equal to the setting never picks up.
- R2: The pickup output is the AND of the comparison and the torque-control input, both taken on a valid tick; with torque control low, pickup stays low whatever the magnitude.
- R3: The timer starts at the valid tick on which pickup asserts (count 0). With a delay setting of D > 0, the trip output asserts at the D-th valid tick after that tick, provided pickup held on every valid tick in between.
- R4: A delay setting of zero makes the trip output assert on the same valid tick as pickup.
- R5: On a valid tick where the pickup condition is false, the count clears and both outputs are low after that tick's clock edge, whether or not a trip had occurred.
- R6: Outputs and count change only at the clock edge of a cycle with the sample-valid strobe high; they hold through cycles with the strobe low.
- R7: While pickup remains asserted after a trip, the count saturates at the delay setting and the trip output stays high without wrapping, however long pickup lasts.
- R8: A synchronous active-high reset clears the count and both outputs to zero.
- R9: Pickup and delay settings are captured on each clock whose pre-edge pickup output is low (or during reset), and held while pickup is high. Changing the setting inputs during timing or after a trip has no effect until pickup drops.
- R10: The trip output is never high while the pickup output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Processing tick: the magnitude and torque inputs are valid this cycle |
| smp_mag | input | MAG_W | Unsigned operating-quantity magnitude |
| set_pickup | input | MAG_W | Pickup threshold setting |
| set_delay | input | DLY_W | Trip delay setting in valid ticks |
| trq_en | input | 1 | Torque-control enable |
| pu_o | output | 1 | Instantaneous pickup flag |
| tmd_o | output | 1 | Delayed trip flag |

## Verification
The hardest condition to reach from the ports is a long, unbroken pickup after a trip, because a wrapping counter would only show after the full counter range has elapsed. The stimulus holds pickup with a short delay for more valid ticks than the count width can represent. A second hard case is a setting change that lands in the middle of timing. Directed phases change the pickup and delay inputs while the element is timing and after it has tripped, then drop pickup to show the new values taking effect. Gaps in the valid strobe are inserted inside the timing window, and a behavioural reference model is compared against the outputs on every clock.

// File: rtl/dt_oc_pkg.sv
package dt_oc_pkg;

    // Element progress through a pickup episode
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TIMING = 2'd1,
        ST_TRIP   = 2'd2
    } dt_state_e;

    // Status pair carried from the timer to the outputs
    typedef struct packed {
        logic pickup;
        logic timed;
    } dt_flags_t;

    function automatic dt_flags_t flags_of(input dt_state_e st);
        dt_flags_t f;
        f.pickup = (st != ST_IDLE);
        f.timed  = (st == ST_TRIP);
        return f;
    endfunction

endpackage

// File: rtl/dt_settings.sv
module dt_settings #(
    parameter int MAG_W = 16,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [MAG_W-1:0] pk_in,
    input  logic [DLY_W-1:0] dly_in,
    output logic [MAG_W-1:0] pk_q,
    output logic [DLY_W-1:0] dly_q
);
    // Capture while idle; freeze while a pickup episode is in progress
    always_ff @(posedge clk) begin
        if (rst || !hold) begin
            pk_q  <= pk_in;
            dly_q <= dly_in;
        end
    end
endmodule

// File: rtl/dt_compare.sv
module dt_compare #(
    parameter int MAG_W = 16
) (
    input  logic [MAG_W-1:0] mag,
    input  logic [MAG_W-1:0] pickup,
    input  logic             torque,
    output logic             pu_now
);
    logic over;
    always_comb begin
        over   = (mag > pickup);
        pu_now = over && torque;
    end
endmodule

// File: rtl/dt_timer.sv
module dt_timer
    import dt_oc_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             pu_now,
    input  logic [DLY_W-1:0] dly,
    output dt_state_e        state_o,
    output logic [DLY_W-1:0] cnt_o
);
    dt_state_e        st_q, st_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic [DLY_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        st_d    = st_q;
        cnt_d   = cnt_q;
        if (tick) begin
            if (!pu_now) begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end else begin
                unique case (st_q)
                    ST_IDLE: begin
                        cnt_d = '0;
                        st_d  = (dly == '0) ? ST_TRIP : ST_TIMING;
                    end
                    ST_TIMING: begin
                        // cnt_q < dly here, so the increment cannot wrap
                        cnt_d = cnt_inc;
                        st_d  = (cnt_inc >= dly) ? ST_TRIP : ST_TIMING;
                    end
                    ST_TRIP: begin
                        cnt_d = cnt_q;
                        st_d  = ST_TRIP;
                    end
                    default: begin
                        cnt_d = '0;
                        st_d  = ST_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state_o = st_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/dt_oc_element.sv
module dt_oc_element
    import dt_oc_pkg::*;
#(
    parameter int MAG_W = 16,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic [MAG_W-1:0] smp_mag,
    input  logic [MAG_W-1:0] set_pickup,
    input  logic [DLY_W-1:0] set_delay,
    input  logic             trq_en,
    output logic             pu_o,
    output logic             tmd_o
);
    logic [MAG_W-1:0] act_pk;
    logic [DLY_W-1:0] act_dly;
    logic [DLY_W-1:0] tmr_cnt;
    logic             pu_now;
    dt_state_e        tmr_st;
    dt_flags_t        flags;

    assign flags = flags_of(tmr_st);
    assign pu_o  = flags.pickup;
    assign tmd_o = flags.timed;

    dt_settings #(.MAG_W(MAG_W), .DLY_W(DLY_W)) u_set (
        .clk    (clk),
        .rst    (rst),
        .hold   (pu_o),
        .pk_in  (set_pickup),
        .dly_in (set_delay),
        .pk_q   (act_pk),
        .dly_q  (act_dly)
    );

    dt_compare #(.MAG_W(MAG_W)) u_cmp (
        .mag    (smp_mag),
        .pickup (act_pk),
        .torque (trq_en),
        .pu_now (pu_now)
    );

    dt_timer #(.DLY_W(DLY_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .tick    (smp_vld),
        .pu_now  (pu_now),
        .dly     (act_dly),
        .state_o (tmr_st),
        .cnt_o   (tmr_cnt)
    );
endmodule

// File: rtl/dt_oc_chk.sv
module dt_oc_chk #(
    parameter int DLY_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_vld,
    input logic             trq_en,
    input logic             pu_o,
    input logic             tmd_o,
    input logic [DLY_W-1:0] tmr_cnt,
    input logic [DLY_W-1:0] act_dly
);
    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b1;
    end

    // R10
    trip_needs_pickup_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        tmd_o |-> pu_o);

    // R8
    reset_clears_chk: assert property (@(posedge clk) disable iff (!seen)
        $past(rst) |-> (!pu_o && !tmd_o && tmr_cnt == '0));

    // R6
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        ($past(!smp_vld) && !$past(rst)) |-> ($stable(pu_o) && $stable(tmd_o) && $stable(tmr_cnt)));

    // R2
    pickup_needs_torque_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        ($rose(pu_o) && !$past(rst)) |-> ($past(trq_en) && $past(smp_vld)));

    // R7
    count_bounded_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        tmr_cnt <= act_dly);

    // R9
    settings_frozen_chk: assert property (@(posedge clk) disable iff (rst || !seen)
        ($past(pu_o) && !$past(rst)) |-> $stable(act_dly));
endmodule

bind dt_oc_element dt_oc_chk #(.DLY_W(DLY_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .smp_vld (smp_vld),
    .trq_en  (trq_en),
    .pu_o    (pu_o),
    .tmd_o   (tmd_o),
    .tmr_cnt (tmr_cnt),
    .act_dly (act_dly)
);

// File: tb/dt_oc_element_bench.sv
module dt_oc_element_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAG_W = 16;
    localparam int DLY_W = 16;
    localparam int WATCHDOG = 190000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             smp_vld = 1'b0;
    logic [MAG_W-1:0] smp_mag = '0;
    logic [MAG_W-1:0] set_pickup = '0;
    logic [DLY_W-1:0] set_delay = '0;
    logic             trq_en = 1'b0;
    logic             pu_o, tmd_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    dt_oc_element #(.MAG_W(MAG_W), .DLY_W(DLY_W)) u_dt_oc_element (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_mag(smp_mag),
        .set_pickup(set_pickup), .set_delay(set_delay), .trq_en(trq_en),
        .pu_o(pu_o), .tmd_o(tmd_o)
    );

    // Behavioural reference
    int    m_pk = 0, m_dly = 0, m_cnt = 0;
    bit    m_pu = 0, m_td = 0;
    int    vectors = 0, errors = 0, cycles = 0;
    string cur_req = "R8";
    bit    done = 0;

    always @(posedge clk) begin
        int npk, ndly;
        bit p;
        npk = m_pk; ndly = m_dly;
        if (rst || !m_pu) begin
            npk = int'(set_pickup);
            ndly = int'(set_delay);
        end
        if (rst) begin
            m_pu = 0; m_td = 0; m_cnt = 0;
        end else if (smp_vld) begin
            p = (int'(smp_mag) > m_pk) && trq_en;
            if (!p) begin
                m_pu = 0; m_td = 0; m_cnt = 0;
            end else begin
                if (!m_pu) m_cnt = 0;
                else if (m_cnt < m_dly) m_cnt = m_cnt + 1;
                m_pu = 1;
                m_td = (m_cnt >= m_dly);
            end
        end
        m_pk = npk; m_dly = ndly;
        cycles++;
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (pu_o !== m_pu) begin
                errors++;
                $display("FAIL %s pickup: actual %b expected %b at cycle %0d", cur_req, pu_o, m_pu, cycles);
            end
            if (tmd_o !== m_td) begin
                errors++;
                $display("FAIL %s trip: actual %b expected %b at cycle %0d", cur_req, tmd_o, m_td, cycles);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    task automatic step(input bit v, input int mag, input bit tq);
        @(negedge clk);
        smp_vld = v; smp_mag = MAG_W'(mag); trq_en = tq;
    endtask

    task automatic run(input int n, input bit v, input int mag, input bit tq);
        for (int i = 0; i < n; i++) step(v, mag, tq);
    endtask

    initial begin
        // R8: reset state
        cur_req = "R8";
        set_pickup = 16'd100; set_delay = 16'd4;
        run(3, 0, 0, 0);
        @(negedge clk); rst = 0;
        run(2, 0, 0, 0);

        // R1: equal to pickup must not pick up, one above must
        cur_req = "R1";
        run(4, 1, 100, 1);
        run(2, 1, 101, 1);
        run(2, 1, 0, 1);

        // R2: torque off blocks any magnitude
        cur_req = "R2";
        run(6, 1, 65535, 0);
        run(2, 1, 500, 1);
        run(1, 1, 500, 0);
        run(2, 1, 0, 0);

        // R3: delay 4 completes with uninterrupted pickup
        cur_req = "R3";
        run(8, 1, 300, 1);
        run(2, 1, 0, 1);

        // R6: valid gaps inside the timing window
        cur_req = "R6";
        for (int i = 0; i < 6; i++) begin
            step(1, 300, 1);
            run(3, 0, 0, 0);
        end
        run(2, 1, 0, 1);

        // R5: interruption before and after trip
        cur_req = "R5";
        run(3, 1, 300, 1);
        run(1, 1, 50, 1);
        run(6, 1, 300, 1);
        run(1, 1, 300, 0);
        run(2, 1, 300, 1);
        run(1, 1, 0, 1);

        // R4: zero delay
        cur_req = "R4";
        set_delay = 16'd0;
        run(2, 1, 0, 1);
        run(3, 1, 300, 1);
        run(1, 1, 0, 1);

        // R9: settings change during timing and after trip
        cur_req = "R9";
        set_delay = 16'd6;
        run(2, 1, 0, 1);
        run(2, 1, 300, 1);
        set_delay = 16'd1; set_pickup = 16'd1000;
        run(8, 1, 300, 1);
        run(1, 1, 0, 1);
        run(3, 1, 300, 1);
        run(2, 1, 1500, 1);
        set_pickup = 16'd100;
        run(3, 1, 1500, 1);
        run(2, 1, 0, 1);

        // R10 and mixed random patterns
        cur_req = "R10";
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) begin
                set_delay = 16'($urandom_range(0, 12));
                set_pickup = 16'($urandom_range(50, 150));
            end
            step($urandom_range(0, 3) != 0, $urandom_range(0, 200), $urandom_range(0, 7) != 0);
        end

        // R7: long hold beyond counter range
        cur_req = "R7";
        set_delay = 16'd3; set_pickup = 16'd100;
        run(2, 1, 0, 1);
        run(66000, 1, 400, 1);
        run(2, 1, 0, 1);

        // R8: reset mid-trip
        cur_req = "R8";
        run(5, 1, 400, 1);
        @(negedge clk); rst = 1;
        run(2, 1, 400, 1);
        @(negedge clk); rst = 0;
        run(6, 1, 400, 1);

        finish_run();
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule